// File: doc/BRIEF.md
# Multi-Queue Word FIFO Manager with Watermark Flags

This block holds a set of small word queues behind a single register-style bus. A write to a queue's access address stores one word at the queue's tail. A read from that address removes the word at the head and returns it. Each queue tracks how many words it holds. Each queue also has two watermark thresholds, one for nearly empty and one for nearly full. The block derives four condition flags per queue from the fill count and these thresholds.

The queues form two groups. The lower group reports all four flags, packed as nibbles into status words, and also keeps sticky underflow and overflow bits. The upper group reports only two flags: nearly empty and full. Each of these is one bit per queue, in two separate words.

Each queue selects one of eight conditions as its interrupt source. The condition sets a per-queue interrupt status bit. Software clears that bit by writing a 1 to it. A per-queue enable bit decides whether the status bit drives the single interrupt line.

The bus decode sorts each access into one of these kinds:

- `ACC_QUEUE`: push or pop.
- `ACC_FLAGS`: lower-group flag words.
- `ACC_ERRS`: sticky error words.
- `ACC_HI_NE`: upper-group nearly-empty word.
- `ACC_HI_FULL`: upper-group full word.
- `ACC_IEN`: interrupt enable register.
- `ACC_ISTAT`: interrupt status register.
- `ACC_CFG`: per-queue configuration.
- `ACC_NONE`: unmapped address.

A `unique case` over the access kind selects the read data and the register updates. The block has no further sequential state machine. Every access completes in the cycle after it is presented.

Top module: `wordq_manager`

## Requirements
- R1: A write to address q (q below the queue count) appends `bus_wdata` to queue q. A read from address q returns that queue's oldest word on `bus_rdata` in the cycle after the read. Each queue is independent and first-in first-out.
- R2: A read from an empty queue returns 0 and removes nothing. For a lower-group queue, it also sets that queue's sticky underflow bit.
- R3: A write to a full queue (fill equals DEPTH) discards the word. For a lower-group queue, it also sets that queue's sticky overflow bit.
- R4: The sticky bits appear at address 0x48 + (q>>4), at bit (q&15)*2 for underflow and bit (q&15)*2+1 for overflow. Writing 1 to a bit clears it. Writing 0 leaves it unchanged.
- R5: Lower-group flags appear at address 0x40 + (q>>3), as a nibble at shift (q&7)*4. Within the nibble, bit 0 is empty, bit 1 is nearly empty, bit 2 is nearly full and bit 3 is full.
- R6: For upper-group queue q, bit (q − NUM_LO) of address 0x50 is nearly empty and bit (q − NUM_LO) of address 0x51 is full. Upper-group queues keep no sticky bits.
- R7: Each queue's configuration word is at address 0x80 + q and reads back as written.
  - Bits [2:0] hold the nearly-empty code and bits [5:3] hold the nearly-full code.
  - Code c means 0 entries when c is 0, and 2^(c−1) entries otherwise.
  - Nearly empty holds when the fill count is at most the nearly-empty level.
  - Nearly full holds when the free space is at most the nearly-full level.
- R8: Configuration bits [8:6] select the interrupt condition:
  - Codes 0 to 3 select empty, nearly empty, nearly full and full.
  - Codes 4 to 7 select the negation of each of those.
  - While the condition holds, bit q of the status register at 0x53 is set one cycle later.
- R9: Writing 1 to a status bit clears it. If its condition still holds, the bit is set again at once.
- R10: `irq` is high exactly when some queue has both its status bit and its enable bit set. The enable bits are at address 0x52, bit q.
- R11: Reset empties every queue and clears all sticky, enable and status bits. It sets every configuration word to zero and drives `irq` low.
- R12: When `bus_wr` and `bus_rd` are high in the same cycle, the write takes effect, the read is ignored and `bus_rdata` keeps its value. An unmapped address reads as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | AW | Word address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, valid the cycle after a read |
| irq | output | 1 | Combined enabled interrupt |

## Verification
The bench fills a queue to its exact depth and then writes once more. A design that misjudges full would either corrupt the oldest word or miss the overflow bit. The bench then drains past empty. A design that moved its pointers on an empty read would return stale data later.

Watermark codes are set so that the flags change at the precise fill counts 4/5 and 14. An off-by-one in the level decode or the at-or-below comparison would shift the nibble by one word.

The interrupt path is exercised with a not-empty source while the condition still holds. This catches a status bit that fails to reassert after clearing, and enabled bits being ignored. Simultaneous read and write, and a mid-run reset, expose a design that pops on a colliding read or leaves state behind.

// File: rtl/wq_pkg.sv
package wq_pkg;

    typedef enum logic [2:0] {
        SRC_EMPTY, SRC_NEMPTY, SRC_NFULL, SRC_FULL,
        SRC_NOT_EMPTY, SRC_NOT_NEMPTY, SRC_NOT_NFULL, SRC_NOT_FULL
    } irq_src_e;

    // configuration word: [8:6] source, [5:3] nearly-full code, [2:0] nearly-empty code
    typedef struct packed {
        irq_src_e   src;
        logic [2:0] nf_code;
        logic [2:0] ne_code;
    } qcfg_t;

    // flag nibble: bit 0 empty, bit 1 nearly empty, bit 2 nearly full, bit 3 full
    typedef struct packed {
        logic full;
        logic nfull;
        logic nempty;
        logic empty;
    } qflags_t;

    typedef enum logic [3:0] {
        ACC_NONE, ACC_QUEUE, ACC_FLAGS, ACC_ERRS, ACC_HI_NE,
        ACC_HI_FULL, ACC_IEN, ACC_ISTAT, ACC_CFG
    } acc_e;

    function automatic logic [6:0] wm_level(input logic [2:0] code);
        return (code == 3'd0) ? 7'd0 : (7'd1 << (code - 3'd1));
    endfunction

endpackage

// File: rtl/wq_queue.sv
module wq_queue #(
    parameter int DW    = 32,
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count
);
    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= step(wr_ptr);
            if (pop)  rd_ptr <= step(rd_ptr);
            unique case ({push, pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    assign head = mem[rd_ptr];

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (count < CW'(DEPTH)));                                    // R3
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (count != '0));                                            // R2
    AST_COUNT_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |=> (count == $past(count) + CW'(1)));              // R1
endmodule

// File: rtl/wq_cond.sv
module wq_cond
    import wq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic [CW-1:0] count,
    input  qcfg_t         cfg,
    output qflags_t       flags,
    output logic          cond
);
    logic [31:0] fill, room, lo_lvl, hi_lvl;

    always_comb begin
        fill   = 32'(count);
        room   = 32'(DEPTH) - fill;
        lo_lvl = 32'(wm_level(cfg.ne_code));
        hi_lvl = 32'(wm_level(cfg.nf_code));
        flags.empty  = (fill == 32'd0);
        flags.full   = (fill == 32'(DEPTH));
        flags.nempty = (fill <= lo_lvl);
        flags.nfull  = (room <= hi_lvl);
        unique case (cfg.src)
            SRC_EMPTY:      cond = flags.empty;
            SRC_NEMPTY:     cond = flags.nempty;
            SRC_NFULL:      cond = flags.nfull;
            SRC_FULL:       cond = flags.full;
            SRC_NOT_EMPTY:  cond = !flags.empty;
            SRC_NOT_NEMPTY: cond = !flags.nempty;
            SRC_NOT_NFULL:  cond = !flags.nfull;
            SRC_NOT_FULL:   cond = !flags.full;
            default:        cond = 1'b0;
        endcase
    end
endmodule

// File: rtl/wordq_manager.sv
module wordq_manager
    import wq_pkg::*;
#(
    parameter int DW     = 32,
    parameter int AW     = 8,
    parameter int NUM_LO = 8,
    parameter int NUM_HI = 8,
    parameter int DEPTH  = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          irq
);
    localparam int NQ         = NUM_LO + NUM_HI;
    localparam int QSW        = $clog2(NQ);
    localparam int CW         = $clog2(DEPTH + 1);
    localparam int FLAG_WORDS = (NUM_LO + 7) / 8;
    localparam int ERR_WORDS  = (NUM_LO + 15) / 16;
    localparam logic [AW-1:0] BASE_FLAG = AW'(8'h40);
    localparam logic [AW-1:0] BASE_ERR  = AW'(8'h48);
    localparam logic [AW-1:0] A_HI_NE   = AW'(8'h50);
    localparam logic [AW-1:0] A_HI_FULL = AW'(8'h51);
    localparam logic [AW-1:0] A_IEN     = AW'(8'h52);
    localparam logic [AW-1:0] A_ISTAT   = AW'(8'h53);
    localparam logic [AW-1:0] BASE_CFG  = AW'(8'h80);

    acc_e          acc;
    logic [AW-1:0] idx;
    logic [QSW-1:0] qsel;
    logic          wr_en, rd_en;

    qcfg_t         cfg   [NQ];
    qflags_t       flg   [NQ];
    logic [DW-1:0] head  [NQ];
    logic [CW-1:0] cnt   [NQ];
    logic [NQ-1:0] q_empty, q_full, push, pop, cond_vec, ien, istat, istat_clr;
    logic [NUM_LO-1:0] unf, ovf;
    logic [FLAG_WORDS*32-1:0] lo_pack;
    logic [ERR_WORDS*32-1:0]  err_pack, err_clr;
    logic [31:0] hi_ne_w, hi_full_w;
    logic [DW-1:0] rdata_n;

    // access decode
    always_comb begin
        acc = ACC_NONE;
        idx = '0;
        if (bus_addr < AW'(NQ)) begin
            acc = ACC_QUEUE; idx = bus_addr;
        end else if (bus_addr >= BASE_FLAG && bus_addr < BASE_FLAG + AW'(FLAG_WORDS)) begin
            acc = ACC_FLAGS; idx = bus_addr - BASE_FLAG;
        end else if (bus_addr >= BASE_ERR && bus_addr < BASE_ERR + AW'(ERR_WORDS)) begin
            acc = ACC_ERRS; idx = bus_addr - BASE_ERR;
        end else if (bus_addr == A_HI_NE) begin
            acc = ACC_HI_NE;
        end else if (bus_addr == A_HI_FULL) begin
            acc = ACC_HI_FULL;
        end else if (bus_addr == A_IEN) begin
            acc = ACC_IEN;
        end else if (bus_addr == A_ISTAT) begin
            acc = ACC_ISTAT;
        end else if (bus_addr >= BASE_CFG && bus_addr < BASE_CFG + AW'(NQ)) begin
            acc = ACC_CFG; idx = bus_addr - BASE_CFG;
        end
    end

    assign qsel  = idx[QSW-1:0];
    assign wr_en = bus_wr;
    assign rd_en = bus_rd && !bus_wr;

    for (genvar q = 0; q < NQ; q++) begin : g_q
        logic hit;
        assign hit        = (acc == ACC_QUEUE) && (qsel == QSW'(q));
        assign q_empty[q] = flg[q].empty;
        assign q_full[q]  = flg[q].full;
        assign push[q]    = wr_en && hit && !flg[q].full;
        assign pop[q]     = rd_en && hit && !flg[q].empty;

        wq_queue #(.DW(DW), .DEPTH(DEPTH)) u_queue (
            .clk(clk), .rst_n(rst_n), .push(push[q]), .pop(pop[q]),
            .wdata(bus_wdata), .head(head[q]), .count(cnt[q]));

        wq_cond #(.DEPTH(DEPTH)) u_cond (
            .count(cnt[q]), .cfg(cfg[q]), .flags(flg[q]), .cond(cond_vec[q]));

        if (q < NUM_LO) begin : g_sticky
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    unf[q] <= 1'b0;
                    ovf[q] <= 1'b0;
                end else begin
                    unf[q] <= (unf[q] && !err_clr[2*q])   || (rd_en && hit && flg[q].empty);
                    ovf[q] <= (ovf[q] && !err_clr[2*q+1]) || (wr_en && hit && flg[q].full);
                end
            end
            AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && hit && flg[q].full) |=> ovf[q]);                 // R3
        end
    end

    // status packing
    always_comb begin
        lo_pack   = '0;
        err_pack  = '0;
        hi_ne_w   = '0;
        hi_full_w = '0;
        err_clr   = '0;
        for (int q = 0; q < NUM_LO; q++) begin
            lo_pack[q*4 +: 4]  = flg[q];
            err_pack[q*2]      = unf[q];
            err_pack[q*2 + 1]  = ovf[q];
        end
        for (int q = NUM_LO; q < NQ; q++) begin
            hi_ne_w[q - NUM_LO]   = flg[q].nempty;
            hi_full_w[q - NUM_LO] = flg[q].full;
        end
        for (int w = 0; w < ERR_WORDS; w++)
            if (wr_en && acc == ACC_ERRS && idx == AW'(w))
                err_clr[w*32 +: 32] = bus_wdata[31:0];
        istat_clr = (wr_en && acc == ACC_ISTAT) ? bus_wdata[NQ-1:0] : '0;
    end

    // read mux
    always_comb begin
        rdata_n = '0;
        unique case (acc)
            ACC_QUEUE:   rdata_n = q_empty[qsel] ? '0 : head[qsel];
            ACC_FLAGS:   for (int w = 0; w < FLAG_WORDS; w++)
                             if (idx == AW'(w)) rdata_n = DW'(lo_pack[w*32 +: 32]);
            ACC_ERRS:    for (int w = 0; w < ERR_WORDS; w++)
                             if (idx == AW'(w)) rdata_n = DW'(err_pack[w*32 +: 32]);
            ACC_HI_NE:   rdata_n = DW'(hi_ne_w);
            ACC_HI_FULL: rdata_n = DW'(hi_full_w);
            ACC_IEN:     rdata_n = DW'(ien);
            ACC_ISTAT:   rdata_n = DW'(istat);
            ACC_CFG:     rdata_n = DW'(cfg[qsel]);
            default:     rdata_n = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
            ien       <= '0;
            istat     <= '0;
            for (int q = 0; q < NQ; q++) cfg[q] <= '0;
        end else begin
            if (rd_en) bus_rdata <= rdata_n;
            if (wr_en && acc == ACC_CFG) cfg[qsel] <= qcfg_t'(bus_wdata[8:0]);
            if (wr_en && acc == ACC_IEN) ien <= bus_wdata[NQ-1:0];
            istat <= (istat & ~istat_clr) | cond_vec;
        end
    end

    assign irq = |(istat & ien);

    AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && acc == ACC_QUEUE && q_empty[qsel]) |=> (bus_rdata == '0));      // R2
    AST_ISTAT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (|cond_vec) |=> ((istat & $past(cond_vec)) == $past(cond_vec)));          // R8
    AST_COLLIDE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_rd) |=> $stable(bus_rdata));                               // R12
    AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (push & q_full) == '0);                                                   // R3
endmodule

// File: tb/wordq_manager_test.sv
`timescale 1ns/1ps
module wordq_manager_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_cmp = 0, n_bad = 0;
    logic [31:0] exp_q [$];
    string       tag_q [$];
    logic        mon_pend = 1'b0;
    logic        done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    wordq_manager uut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

    // monitor: compare read data the cycle after each read
    always @(posedge clk) mon_pend <= rst_n && bus_rd && !bus_wr;
    always @(negedge clk) begin
        if (mon_pend) begin
            n_cmp++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL unexpected read: actual %h expected none", bus_rdata);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (bus_rdata !== e) begin
                    n_bad++;
                    $display("FAIL %s: actual %h expected %h", t, bus_rdata, e);
                end
            end
        end
    end

    task automatic idle();
        @(negedge clk);
        bus_wr = 0; bus_rd = 0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1; bus_rd = 0;
        @(posedge clk); #1;
        bus_wr = 0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        exp_q.push_back(e); tag_q.push_back(t);
        bus_addr = a; bus_rd = 1; bus_wr = 0;
        @(posedge clk); #1;
        bus_rd = 0;
    endtask

    task automatic chk_irq(input logic e, input string t);
        idle(); idle();
        n_cmp++;
        if (irq !== e) begin
            n_bad++;
            $display("FAIL %s: irq actual %b expected %b", t, irq, e);
        end
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        idle();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        idle(); idle();

        // R11 reset state
        rd(8'h40, 32'h3333_3333, "R11 R5 flags after reset");
        rd(8'h50, 32'h0000_00FF, "R11 R6 upper nearly empty after reset");
        rd(8'h51, 32'h0, "R11 upper full after reset");
        rd(8'h48, 32'h0, "R11 sticky after reset");
        rd(8'h52, 32'h0, "R11 enable after reset");
        rd(8'h84, 32'h0, "R11 cfg after reset");
        rd(8'h53, 32'h0000_FFFF, "R8 empty source sets status");
        chk_irq(1'b0, "R11 R10 irq after reset");

        // R1 ordering across two queues
        wr(8'd2, 32'hA0); wr(8'd9, 32'hB0); wr(8'd2, 32'hA1); wr(8'd2, 32'hA2); wr(8'd9, 32'hB1);
        rd(8'd2, 32'hA0, "R1 q2 first"); rd(8'd9, 32'hB0, "R1 q9 first");
        rd(8'd2, 32'hA1, "R1 q2 second"); rd(8'd2, 32'hA2, "R1 q2 third");
        rd(8'd9, 32'hB1, "R1 q9 second");

        // R5 nibble position
        wr(8'd3, 32'h55);
        rd(8'h40, 32'h3333_0333, "R5 q3 nibble");
        rd(8'd3, 32'h55, "R1 q3 pop");

        // R2 / R4 underflow
        rd(8'd1, 32'h0, "R2 empty read returns zero");
        rd(8'h48, 32'h0000_0004, "R2 R4 underflow bit q1");
        wr(8'h48, 32'h0000_0004);
        rd(8'h48, 32'h0, "R4 write-one clear");

        // R3 overflow on q0
        for (int i = 0; i < 16; i++) wr(8'd0, 32'h100 + i);
        wr(8'd0, 32'hDEAD);
        rd(8'h40, 32'h3333_333C, "R3 R5 q0 full flags");
        rd(8'h48, 32'h0000_0002, "R3 R4 overflow bit q0");
        for (int i = 0; i < 16; i++) rd(8'd0, 32'h100 + i, "R3 R1 q0 drain order");
        rd(8'd0, 32'h0, "R2 q0 past empty");
        rd(8'h48, 32'h0000_0003, "R4 both sticky bits q0");
        wr(8'h48, 32'h0000_0001);
        rd(8'h48, 32'h0000_0002, "R4 partial clear");
        wr(8'h48, 32'h0000_0002);

        // R7 watermarks on q4: ne code 3 (4), nf code 2 (2)
        wr(8'h84, 32'h13);
        rd(8'h84, 32'h13, "R7 cfg readback");
        for (int i = 0; i < 4; i++) wr(8'd4, i);
        rd(8'h40, 32'h3332_3333, "R7 fill 4 nearly empty");
        wr(8'd4, 32'd4);
        rd(8'h40, 32'h3330_3333, "R7 fill 5 not nearly empty");
        for (int i = 5; i < 14; i++) wr(8'd4, i);
        rd(8'h40, 32'h3334_3333, "R7 fill 14 nearly full");
        for (int i = 0; i < 14; i++) rd(8'd4, i, "R7 R1 q4 drain");

        // R6 upper queue q12
        for (int i = 0; i < 16; i++) wr(8'd12, 32'h200 + i);
        wr(8'd12, 32'hBEEF);
        rd(8'h50, 32'h0000_00EF, "R6 upper nearly empty");
        rd(8'h51, 32'h0000_0010, "R6 upper full");
        rd(8'h48, 32'h0, "R6 no sticky for upper");
        for (int i = 0; i < 16; i++) rd(8'd12, 32'h200 + i, "R6 R3 q12 drain");

        // R8 / R9 / R10 interrupt on q5, source not-empty
        wr(8'h85, 32'h100);
        wr(8'h52, 32'h20);
        wr(8'h53, 32'hFFFF);
        chk_irq(1'b0, "R10 masked others, q5 condition false");
        rd(8'h53, 32'h0000_FFDF, "R9 reassert of held conditions");
        wr(8'd5, 32'h77);
        chk_irq(1'b1, "R8 not-empty raises irq");
        wr(8'h53, 32'h20);
        chk_irq(1'b1, "R9 clear while condition holds");
        rd(8'd5, 32'h77, "R1 q5 pop");
        chk_irq(1'b1, "R9 status sticky after condition ends");
        wr(8'h53, 32'h20);
        chk_irq(1'b0, "R9 clear after condition ends");
        wr(8'h52, 32'h0);
        wr(8'd5, 32'h78);
        chk_irq(1'b0, "R10 disabled status does not drive irq");
        rd(8'h53, 32'h0000_FFFF, "R8 status set while disabled");
        rd(8'd5, 32'h78, "R1 q5 pop again");

        // R12 collision
        @(negedge clk);
        bus_addr = 8'd6; bus_wdata = 32'hABCD; bus_wr = 1; bus_rd = 1;
        @(posedge clk); #1;
        bus_wr = 0; bus_rd = 0;
        rd(8'd6, 32'hABCD, "R12 write wins over read");
        rd(8'd6, 32'h0, "R12 read was not a pop");
        rd(8'h48, 32'h0000_1000, "R2 underflow bit q6");
        rd(8'h60, 32'h0, "R12 unmapped reads zero");
        drain();

        // R11 mid-run reset
        wr(8'd2, 32'h99); wr(8'h52, 32'hFFFF); wr(8'h84, 32'h5);
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        idle();
        rd(8'h40, 32'h3333_3333, "R11 queues emptied by reset");
        rd(8'h48, 32'h0, "R11 sticky cleared by reset");
        rd(8'h84, 32'h0, "R11 cfg cleared by reset");
        rd(8'h52, 32'h0, "R11 enable cleared by reset");
        drain();

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule